// File: doc/BRIEF.md
# Paravirtual Device Control Register Window

This block is the guest-facing register window of a paravirtualized I/O device. A guest driver reaches it over a plain 32-bit memory-mapped bus made of an address, a write strobe with write data, and a read strobe with read data. The window answers identification reads. It negotiates a 64-bit feature set through 32-bit windows picked by selector registers. It also holds the guest page size and a status word.

Per-queue settings are size, used-ring alignment and ring page number. They sit in banks, and a queue selector register chooses which bank the bus reaches. The host side reads any bank through a separate index port. A write to the notify offset sends the host a one-cycle pulse that carries the queue index. A zero write to status gives a one-cycle device reset pulse and wipes the negotiated and per-queue state. A host event raises one level interrupt, and a guest acknowledge write drops it. A small byte-wide configuration area starts at offset 0x100.

Read data is registered. A read strobe sampled at one clock edge shows its word from that edge onward, and the word holds until the next read strobe.

Top module: `pvdev_regs`

## Requirements
- R1: Reads of the identity offsets return fixed words: 0x000 gives 0x74726976, 0x004 gives 1, 0x008 gives DEVICE_ID and 0x00C gives VENDOR_ID. The word appears on rd_data the cycle after rd_en is sampled and holds until the next read.
- R2: A read of 0x010 returns host feature bits [sel*32 +: 32], where sel is the last value written to 0x014. It returns zero when sel is 2 or more.
- R3: A write to 0x020 stores its data in guest feature bits [sel*32 +: 32], where sel is the last value written to 0x024. With sel at 2 or more the write is ignored. The full vector is shown on guest_feats.
- R4: Writes to 0x038 (size), 0x03C (alignment) and 0x040 (page number) land in the queue bank last chosen through 0x030. A read of 0x040 returns the chosen bank's page number. The host port shows the bank indexed by host_qsel.
- R5: A read of 0x034 returns QMAX_SIZE when the chosen queue index is below NUM_QUEUES, and zero otherwise. Size, alignment and page number writes aimed at a missing queue change no bank.
- R6: host_qlive is 1 exactly when the indexed queue's page number is nonzero. Writing zero to 0x040 releases the queue, and both host_qlive and the readback return to zero.
- R7: A write of a value below NUM_QUEUES to 0x050 gives notify_pulse high for exactly the next cycle, with notify_qidx equal to that value. A larger value gives no pulse.
- R8: A nonzero write to 0x070 ORs its data into the status word. Status bits never drop except on a device reset.
- R9: A zero write to 0x070 gives dev_reset_pulse high for the next cycle. It clears status, guest features, both feature selectors, the queue selector, page size, every queue bank and the interrupt. The configuration bytes are kept.
- R10: irq goes to 1 the cycle after irq_set and goes to 0 after any write to 0x060. When both happen in the same cycle the interrupt stays set. A device reset in that cycle clears it.
- R11: Reads of write-only or unmapped offsets return zero, and writes to read-only offsets change nothing.
- R12: Offsets 0x100 to 0x100+CFG_BYTES-1 each hold one byte. A write stores wr_data[7:0], a read returns the byte zero-extended, and offsets past the area read zero and ignore writes.
- R13: A write to 0x028 sets page_size.
- R14: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_set | input | 1 | Host-side event that raises the interrupt |
| irq | output | 1 | Level interrupt to the guest |
| notify_pulse | output | 1 | One-cycle queue notification |
| notify_qidx | output | QIDX_W | Queue index of the last notification |
| dev_reset_pulse | output | 1 | One-cycle device reset request |
| dev_status | output | 32 | Status word |
| guest_feats | output | 64 | Features accepted by the guest |
| page_size | output | 32 | Guest page size in bytes |
| host_qsel | input | QIDX_W | Host-side queue bank index |
| host_qsize | output | 32 | Size of the indexed queue |
| host_qalign | output | 32 | Used-ring alignment of the indexed queue |
| host_qpfn | output | 32 | Page number of the indexed queue |
| host_qlive | output | 1 | Indexed queue is in use |

## Verification
The properties assume a driver that never raises wr_en and rd_en in the same cycle. They also assume the inputs are at known values from time zero. That lets each pulse be traced back to the single bus write one cycle earlier. The stimulus keeps to this by issuing one access per call, with an idle cycle between calls. host_qsel only ever names existing banks, and irq_set is raised only as isolated events, or together with an acknowledge or a reset write when the priority rule is under test.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
   // register offsets; the bus decodes these directly
   localparam logic [11:0] OFF_MAGIC    = 12'h000;
   localparam logic [11:0] OFF_VERSION  = 12'h004;
   localparam logic [11:0] OFF_DEVID    = 12'h008;
   localparam logic [11:0] OFF_VENDID   = 12'h00C;
   localparam logic [11:0] OFF_HFEAT    = 12'h010;
   localparam logic [11:0] OFF_HSEL     = 12'h014;
   localparam logic [11:0] OFF_GFEAT    = 12'h020;
   localparam logic [11:0] OFF_GSEL     = 12'h024;
   localparam logic [11:0] OFF_PAGE     = 12'h028;
   localparam logic [11:0] OFF_QSEL     = 12'h030;
   localparam logic [11:0] OFF_QMAX     = 12'h034;
   localparam logic [11:0] OFF_QSIZE    = 12'h038;
   localparam logic [11:0] OFF_QALIGN   = 12'h03C;
   localparam logic [11:0] OFF_QPFN     = 12'h040;
   localparam logic [11:0] OFF_NOTIFY   = 12'h050;
   localparam logic [11:0] OFF_ACK      = 12'h060;
   localparam logic [11:0] OFF_STATUS   = 12'h070;
   localparam logic [11:0] OFF_CFG_BASE = 12'h100;

   // ASCII "virt", first character in the low byte
   localparam logic [31:0] MAGIC_WORD   = 32'h7472_6976;
   localparam logic [31:0] VERSION_WORD = 32'd1;
endpackage

// File: rtl/pvdev_feat.sv
// Windowed feature negotiation: host set read, guest set written, 32 bits at a time.
module pvdev_feat #(
   parameter int          FEAT_W     = 64,
   parameter logic [63:0] HOST_FEATS = '0,
   localparam int         WIN_W      = 32,
   localparam int         NWIN       = FEAT_W / WIN_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hsel_we,
   input  logic              gsel_we,
   input  logic              gfeat_we,
   input  logic [31:0]       wdata,
   output logic [31:0]       host_win,
   output logic [FEAT_W-1:0] guest_feats
);
   if (FEAT_W % WIN_W != 0 || FEAT_W > 64) begin : g_bad_feat_w
      $error("pvdev_feat: FEAT_W must be a multiple of 32 and at most 64");
   end

   logic [31:0] hsel_q, gsel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsel_q <= '0;
         gsel_q <= '0;
      end else if (clr) begin
         hsel_q <= '0;
         gsel_q <= '0;
      end else begin
         if (hsel_we) hsel_q <= wdata;
         if (gsel_we) gsel_q <= wdata;
      end
   end

   // one storage word per window
   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic [WIN_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (clr)
            word_q <= '0;
         else if (gfeat_we && gsel_q == 32'(w))
            word_q <= wdata;
      end
      assign guest_feats[w*WIN_W +: WIN_W] = word_q;
   end

   always_comb begin
      host_win = '0;
      for (int w = 0; w < NWIN; w++) begin
         if (hsel_q == 32'(w)) host_win = HOST_FEATS[w*WIN_W +: WIN_W];
      end
   end
endmodule

// File: rtl/pvdev_qbank.sv
// Per-queue setting banks, addressed by the guest selector and by a host index.
module pvdev_qbank #(
   parameter int  NUM_QUEUES = 4,
   localparam int QIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [31:0]       qsel,
   input  logic              size_we,
   input  logic              align_we,
   input  logic              pfn_we,
   input  logic [31:0]       wdata,
   output logic              sel_ok,
   output logic [31:0]       sel_pfn,
   input  logic [QIDX_W-1:0] host_qsel,
   output logic [31:0]       host_qsize,
   output logic [31:0]       host_qalign,
   output logic [31:0]       host_qpfn,
   output logic              host_qlive
);
   logic [NUM_QUEUES-1:0][31:0] size_a, align_a, pfn_a;

   for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
      logic        hit;
      logic [31:0] size_q, align_q, pfn_q;
      assign hit = (qsel == 32'(q));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q  <= '0;
            align_q <= '0;
            pfn_q   <= '0;
         end else if (clr) begin
            size_q  <= '0;
            align_q <= '0;
            pfn_q   <= '0;
         end else if (hit) begin
            if (size_we)  size_q  <= wdata;
            if (align_we) align_q <= wdata;
            if (pfn_we)   pfn_q   <= wdata;
         end
      end
      assign size_a[q]  = size_q;
      assign align_a[q] = align_q;
      assign pfn_a[q]   = pfn_q;
   end

   assign sel_ok = (qsel < 32'(NUM_QUEUES));

   always_comb begin
      sel_pfn     = '0;
      host_qsize  = '0;
      host_qalign = '0;
      host_qpfn   = '0;
      for (int q = 0; q < NUM_QUEUES; q++) begin
         if (qsel == 32'(q)) sel_pfn = pfn_a[q];
         if (host_qsel == QIDX_W'(q)) begin
            host_qsize  = size_a[q];
            host_qalign = align_a[q];
            host_qpfn   = pfn_a[q];
         end
      end
   end

   assign host_qlive = (host_qpfn != '0);
endmodule

// File: rtl/pvdev_cfg.sv
// Byte-wide device-specific configuration area.
module pvdev_cfg import pvdev_pkg::*; #(
   parameter int  ADDR_W    = 12,
   parameter int  CFG_BYTES = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [7:0]        wbyte,
   output logic              hit,
   output logic [7:0]        rbyte
);
   logic [ADDR_W-1:0]          off;
   logic [CFG_BYTES-1:0][7:0]  bytes_a;

   assign off = addr - ADDR_W'(OFF_CFG_BASE);
   assign hit = (addr >= ADDR_W'(OFF_CFG_BASE)) && (off < ADDR_W'(CFG_BYTES));

   for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= '0;
         else if (wr_en && hit && off == ADDR_W'(b))
            byte_q <= wbyte;
      end
      assign bytes_a[b] = byte_q;
   end

   always_comb begin
      rbyte = '0;
      for (int b = 0; b < CFG_BYTES; b++) begin
         if (hit && off == ADDR_W'(b)) rbyte = bytes_a[b];
      end
   end
endmodule

// File: rtl/pvdev_regs.sv
// Control register window of a paravirtual device.
module pvdev_regs import pvdev_pkg::*; #(
   parameter int          ADDR_W     = 12,
   parameter int          NUM_QUEUES = 4,
   parameter int          QMAX_SIZE  = 256,
   parameter int          CFG_BYTES  = 16,
   parameter logic [63:0] HOST_FEATS = 64'h0000_0003_0100_0021,
   parameter logic [31:0] DEVICE_ID  = 32'd1,
   parameter logic [31:0] VENDOR_ID  = 32'h0000_5A17,
   localparam int         QIDX_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   output logic [31:0]       rd_data,
   input  logic              irq_set,
   output logic              irq,
   output logic              notify_pulse,
   output logic [QIDX_W-1:0] notify_qidx,
   output logic              dev_reset_pulse,
   output logic [31:0]       dev_status,
   output logic [63:0]       guest_feats,
   output logic [31:0]       page_size,
   input  logic [QIDX_W-1:0] host_qsel,
   output logic [31:0]       host_qsize,
   output logic [31:0]       host_qalign,
   output logic [31:0]       host_qpfn,
   output logic              host_qlive
);
   if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr_w
      $error("pvdev_regs: ADDR_W must lie in 9..32");
   end
   if (NUM_QUEUES < 1 || NUM_QUEUES > 64) begin : g_bad_nq
      $error("pvdev_regs: NUM_QUEUES must lie in 1..64");
   end
   if (QMAX_SIZE < 1 || QMAX_SIZE > 32768) begin : g_bad_qmax
      $error("pvdev_regs: QMAX_SIZE must lie in 1..32768");
   end
   if (CFG_BYTES < 1 || CFG_BYTES > 256) begin : g_bad_cfg
      $error("pvdev_regs: CFG_BYTES must lie in 1..256");
   end

   // write strobes
   logic we_hsel, we_gsel, we_gfeat, we_page, we_qsel;
   logic we_qsize, we_qalign, we_qpfn, we_notify, we_ack, we_stat;
   logic dev_clr, notify_ok;

   always_comb begin
      we_hsel   = wr_en && (addr == ADDR_W'(OFF_HSEL));
      we_gsel   = wr_en && (addr == ADDR_W'(OFF_GSEL));
      we_gfeat  = wr_en && (addr == ADDR_W'(OFF_GFEAT));
      we_page   = wr_en && (addr == ADDR_W'(OFF_PAGE));
      we_qsel   = wr_en && (addr == ADDR_W'(OFF_QSEL));
      we_qsize  = wr_en && (addr == ADDR_W'(OFF_QSIZE));
      we_qalign = wr_en && (addr == ADDR_W'(OFF_QALIGN));
      we_qpfn   = wr_en && (addr == ADDR_W'(OFF_QPFN));
      we_notify = wr_en && (addr == ADDR_W'(OFF_NOTIFY));
      we_ack    = wr_en && (addr == ADDR_W'(OFF_ACK));
      we_stat   = wr_en && (addr == ADDR_W'(OFF_STATUS));
      dev_clr   = we_stat && (wr_data == '0);
      notify_ok = we_notify && (wr_data < 32'(NUM_QUEUES));
   end

   logic [31:0] qsel_q;
   logic [31:0] host_win;
   logic        qsel_ok;
   logic [31:0] sel_pfn;
   logic        cfg_hit;
   logic [7:0]  cfg_byte;

   pvdev_feat #(
      .FEAT_W     (64),
      .HOST_FEATS (HOST_FEATS)
   ) u_feat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (dev_clr),
      .hsel_we     (we_hsel),
      .gsel_we     (we_gsel),
      .gfeat_we    (we_gfeat),
      .wdata       (wr_data),
      .host_win    (host_win),
      .guest_feats (guest_feats)
   );

   pvdev_qbank #(
      .NUM_QUEUES (NUM_QUEUES)
   ) u_qbank (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (dev_clr),
      .qsel        (qsel_q),
      .size_we     (we_qsize),
      .align_we    (we_qalign),
      .pfn_we      (we_qpfn),
      .wdata       (wr_data),
      .sel_ok      (qsel_ok),
      .sel_pfn     (sel_pfn),
      .host_qsel   (host_qsel),
      .host_qsize  (host_qsize),
      .host_qalign (host_qalign),
      .host_qpfn   (host_qpfn),
      .host_qlive  (host_qlive)
   );

   pvdev_cfg #(
      .ADDR_W    (ADDR_W),
      .CFG_BYTES (CFG_BYTES)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr_en (wr_en),
      .wbyte (wr_data[7:0]),
      .hit   (cfg_hit),
      .rbyte (cfg_byte)
   );

   // read multiplexer; write-only and unmapped offsets fall through to zero
   logic [31:0] rd_next;
   always_comb begin
      case (addr)
         ADDR_W'(OFF_MAGIC):   rd_next = MAGIC_WORD;
         ADDR_W'(OFF_VERSION): rd_next = VERSION_WORD;
         ADDR_W'(OFF_DEVID):   rd_next = DEVICE_ID;
         ADDR_W'(OFF_VENDID):  rd_next = VENDOR_ID;
         ADDR_W'(OFF_HFEAT):   rd_next = host_win;
         ADDR_W'(OFF_QMAX):    rd_next = qsel_ok ? 32'(QMAX_SIZE) : '0;
         ADDR_W'(OFF_QPFN):    rd_next = sel_pfn;
         ADDR_W'(OFF_STATUS):  rd_next = dev_status;
         default:              rd_next = cfg_hit ? {24'b0, cfg_byte} : '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data         <= '0;
         dev_status      <= '0;
         page_size       <= '0;
         qsel_q          <= '0;
         irq             <= 1'b0;
         notify_pulse    <= 1'b0;
         notify_qidx     <= '0;
         dev_reset_pulse <= 1'b0;
      end else begin
         dev_reset_pulse <= dev_clr;
         notify_pulse    <= notify_ok;
         if (notify_ok) notify_qidx <= wr_data[QIDX_W-1:0];
         if (rd_en) rd_data <= rd_next;

         if (dev_clr) begin
            dev_status <= '0;
            page_size  <= '0;
            qsel_q     <= '0;
         end else begin
            if (we_stat) dev_status <= dev_status | wr_data;
            if (we_page) page_size  <= wr_data;
            if (we_qsel) qsel_q     <= wr_data;
         end

         // device reset beats a new event, a new event beats an acknowledge
         if (dev_clr)      irq <= 1'b0;
         else if (irq_set) irq <= 1'b1;
         else if (we_ack)  irq <= 1'b0;
      end
   end
endmodule

// File: rtl/pvdev_regs_chk.sv
module pvdev_regs_chk import pvdev_pkg::*; #(
   parameter int ADDR_W = 12,
   parameter int QIDX_W = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [31:0]       wr_data,
   input logic              rd_en,
   input logic [31:0]       rd_data,
   input logic              irq_set,
   input logic              irq,
   input logic              notify_pulse,
   input logic [QIDX_W-1:0] notify_qidx,
   input logic              dev_reset_pulse,
   input logic [31:0]       dev_status,
   input logic [63:0]       guest_feats,
   input logic [31:0]       page_size
);
   logic zero_stat_wr;
   assign zero_stat_wr = wr_en && (addr == ADDR_W'(OFF_STATUS)) && (wr_data == '0);

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(rd_en) |-> $stable(rd_data)); // R1
   AST_NOTIFY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) notify_pulse |-> $past(wr_en && addr == ADDR_W'(OFF_NOTIFY))); // R7
   AST_NOTIFY_INDEX: assert property (@(posedge clk) disable iff (!rst_n) notify_pulse |-> notify_qidx == $past(wr_data[QIDX_W-1:0])); // R7
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !dev_reset_pulse |-> ((dev_status & $past(dev_status)) == $past(dev_status))); // R8
   AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) dev_reset_pulse |-> $past(zero_stat_wr)); // R9
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) dev_reset_pulse |-> (dev_status == '0 && guest_feats == '0 && page_size == '0 && !irq)); // R9
   AST_IRQ_SETS: assert property (@(posedge clk) disable iff (!rst_n) (irq_set && !zero_stat_wr) |=> irq); // R10
   AST_IRQ_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> $past(wr_en && (addr == ADDR_W'(OFF_ACK) || (addr == ADDR_W'(OFF_STATUS) && wr_data == '0)))); // R10
endmodule

bind pvdev_regs pvdev_regs_chk #(
   .ADDR_W (ADDR_W),
   .QIDX_W (QIDX_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .addr            (addr),
   .wr_en           (wr_en),
   .wr_data         (wr_data),
   .rd_en           (rd_en),
   .rd_data         (rd_data),
   .irq_set         (irq_set),
   .irq             (irq),
   .notify_pulse    (notify_pulse),
   .notify_qidx     (notify_qidx),
   .dev_reset_pulse (dev_reset_pulse),
   .dev_status      (dev_status),
   .guest_feats     (guest_feats),
   .page_size       (page_size)
);

// File: tb/pvdev_regs_bench.sv
`timescale 1ns/1ps
module pvdev_regs_bench;
   localparam int          NQ   = 4;
   localparam int          QMAX = 256;
   localparam int          CFGB = 16;
   localparam logic [63:0] HF   = 64'h0000_0003_0100_0021;
   localparam logic [31:0] DEV  = 32'd1;
   localparam logic [31:0] VEND = 32'h0000_5A17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        irq_set = 1'b0;
   logic [1:0]  host_qsel = '0;
   logic [31:0] rd_data, dev_status, page_size, host_qsize, host_qalign, host_qpfn;
   logic [63:0] guest_feats;
   logic        irq, notify_pulse, dev_reset_pulse, host_qlive;
   logic [1:0]  notify_qidx;

   always #2.5 clk = ~clk;

   pvdev_regs #(
      .ADDR_W(12), .NUM_QUEUES(NQ), .QMAX_SIZE(QMAX), .CFG_BYTES(CFGB),
      .HOST_FEATS(HF), .DEVICE_ID(DEV), .VENDOR_ID(VEND)
   ) u_pvdev_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .irq_set(irq_set), .irq(irq),
      .notify_pulse(notify_pulse), .notify_qidx(notify_qidx),
      .dev_reset_pulse(dev_reset_pulse), .dev_status(dev_status),
      .guest_feats(guest_feats), .page_size(page_size), .host_qsel(host_qsel),
      .host_qsize(host_qsize), .host_qalign(host_qalign), .host_qpfn(host_qpfn),
      .host_qlive(host_qlive)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string cur_tag = "R14";

   task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endtask

   // behavioural reference model
   logic [31:0] m_rd, m_stat, m_page, m_qsel, m_hsel, m_gsel;
   logic [63:0] m_gf;
   logic [31:0] m_qsize [NQ];
   logic [31:0] m_qalign[NQ];
   logic [31:0] m_qpfn  [NQ];
   logic [7:0]  m_cfg   [CFGB];
   logic        m_irq, m_ntf, m_rst;
   logic [1:0]  m_nidx;

   function automatic logic [31:0] mread(input logic [11:0] a);
      int sel;
      if (a == 12'h000) return 32'h7472_6976;
      if (a == 12'h004) return 32'd1;
      if (a == 12'h008) return DEV;
      if (a == 12'h00C) return VEND;
      if (a == 12'h010) begin
         if (m_hsel == 0) return HF[31:0];
         if (m_hsel == 1) return HF[63:32];
         return 0;
      end
      if (a == 12'h034) return (m_qsel < NQ) ? QMAX : 0;
      if (a == 12'h040) begin
         sel = int'(m_qsel);
         return (m_qsel < NQ) ? m_qpfn[sel] : 0;
      end
      if (a == 12'h070) return m_stat;
      if (a >= 12'h100 && a < 12'h100 + CFGB) return {24'b0, m_cfg[int'(a) - 256]};
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rd = 0; m_stat = 0; m_page = 0; m_qsel = 0; m_hsel = 0; m_gsel = 0;
         m_gf = 0; m_irq = 0; m_ntf = 0; m_rst = 0; m_nidx = 0;
         for (int i = 0; i < NQ; i++) begin m_qsize[i] = 0; m_qalign[i] = 0; m_qpfn[i] = 0; end
         for (int i = 0; i < CFGB; i++) m_cfg[i] = 0;
      end else begin
         logic clr;
         clr = wr_en && addr == 12'h070 && wr_data == 0;
         m_ntf = 0;
         m_rst = clr;
         if (rd_en) m_rd = mread(addr);
         if (clr) m_irq = 0;
         else if (irq_set) m_irq = 1;
         else if (wr_en && addr == 12'h060) m_irq = 0;
         if (clr) begin
            m_stat = 0; m_page = 0; m_qsel = 0; m_hsel = 0; m_gsel = 0; m_gf = 0;
            for (int i = 0; i < NQ; i++) begin m_qsize[i] = 0; m_qalign[i] = 0; m_qpfn[i] = 0; end
         end else if (wr_en) begin
            case (addr)
               12'h014: m_hsel = wr_data;
               12'h024: m_gsel = wr_data;
               12'h020: if (m_gsel == 0) m_gf[31:0] = wr_data; else if (m_gsel == 1) m_gf[63:32] = wr_data;
               12'h028: m_page = wr_data;
               12'h030: m_qsel = wr_data;
               12'h038: if (m_qsel < NQ) m_qsize[int'(m_qsel)] = wr_data;
               12'h03C: if (m_qsel < NQ) m_qalign[int'(m_qsel)] = wr_data;
               12'h040: if (m_qsel < NQ) m_qpfn[int'(m_qsel)] = wr_data;
               12'h050: if (wr_data < NQ) begin m_ntf = 1; m_nidx = wr_data[1:0]; end
               12'h070: m_stat = m_stat | wr_data;
               default: ;
            endcase
            if (addr >= 12'h100 && addr < 12'h100 + CFGB) m_cfg[int'(addr) - 256] = wr_data[7:0];
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_tag, "rd_data", 64'(rd_data), 64'(m_rd));
         chk("R7", "notify_pulse", 64'(notify_pulse), 64'(m_ntf));
         chk("R7", "notify_qidx", 64'(notify_qidx), 64'(m_nidx));
         chk("R9", "dev_reset_pulse", 64'(dev_reset_pulse), 64'(m_rst));
         chk("R10", "irq", 64'(irq), 64'(m_irq));
         chk("R8", "dev_status", 64'(dev_status), 64'(m_stat));
         chk("R3", "guest_feats", guest_feats, m_gf);
         chk("R13", "page_size", 64'(page_size), 64'(m_page));
         chk("R4", "host_qsize", 64'(host_qsize), 64'(m_qsize[host_qsel]));
         chk("R4", "host_qalign", 64'(host_qalign), 64'(m_qalign[host_qsel]));
         chk("R4", "host_qpfn", 64'(host_qpfn), 64'(m_qpfn[host_qsel]));
         chk("R6", "host_qlive", 64'(host_qlive), 64'(m_qpfn[host_qsel] != 0));
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      @(posedge clk); #1;
      addr = a; rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      v = rd_data;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL R14 watchdog got 0 exp 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk("R14", "rd_data", 64'(rd_data), 0);
      chk("R14", "irq", 64'(irq), 0);
      chk("R14", "dev_status", 64'(dev_status), 0);
      chk("R14", "guest_feats", guest_feats, 0);

      cur_tag = "R1";
      rd(12'h000, v); chk("R1", "magic", 64'(v), 64'h7472_6976);
      rd(12'h004, v); chk("R1", "version", 64'(v), 1);
      rd(12'h008, v); chk("R1", "device id", 64'(v), 64'(DEV));
      rd(12'h00C, v); chk("R1", "vendor id", 64'(v), 64'(VEND));
      repeat (3) @(posedge clk); #1;
      chk("R1", "rd_data hold", 64'(rd_data), 64'(VEND));

      cur_tag = "R2";
      wr(12'h014, 0); rd(12'h010, v); chk("R2", "host win 0", 64'(v), 64'(HF[31:0]));
      wr(12'h014, 1); rd(12'h010, v); chk("R2", "host win 1", 64'(v), 64'(HF[63:32]));
      wr(12'h014, 5); rd(12'h010, v); chk("R2", "host win 5", 64'(v), 0);

      cur_tag = "R3";
      wr(12'h024, 1); wr(12'h020, 32'hAAAA_5555);
      wr(12'h024, 0); wr(12'h020, 32'h1234_5678);
      wr(12'h024, 2); wr(12'h020, 32'hFFFF_FFFF);
      chk("R3", "guest_feats", guest_feats, 64'hAAAA_5555_1234_5678);

      cur_tag = "R4";
      for (int q = 0; q < NQ; q++) begin
         wr(12'h030, q);
         wr(12'h038, 16 + q);
         wr(12'h03C, 32'h1000 << q);
         wr(12'h040, 32'h100 + q);
      end
      host_qsel = 2'd2; #1;
      chk("R4", "host_qpfn q2", 64'(host_qpfn), 64'h102);
      chk("R4", "host_qsize q2", 64'(host_qsize), 18);
      chk("R4", "host_qalign q2", 64'(host_qalign), 64'h4000);
      rd(12'h040, v); chk("R4", "pfn readback q3", 64'(v), 64'h103);

      cur_tag = "R5";
      rd(12'h034, v); chk("R5", "qmax q3", 64'(v), QMAX);
      wr(12'h030, 7);
      rd(12'h034, v); chk("R5", "qmax missing", 64'(v), 0);
      wr(12'h038, 32'h77); wr(12'h03C, 32'h77); wr(12'h040, 32'h999);
      for (int q = 0; q < NQ; q++) begin
         host_qsel = 2'(q); #1;
         chk("R5", "bank untouched pfn", 64'(host_qpfn), 64'(32'h100 + q));
         chk("R5", "bank untouched size", 64'(host_qsize), 64'(16 + q));
      end

      cur_tag = "R6";
      wr(12'h030, 1); wr(12'h040, 0);
      rd(12'h040, v); chk("R6", "released pfn", 64'(v), 0);
      host_qsel = 2'd1; #1; chk("R6", "q1 live", 64'(host_qlive), 0);
      host_qsel = 2'd0; #1; chk("R6", "q0 live", 64'(host_qlive), 1);

      cur_tag = "R7";
      wr(12'h050, 2);
      chk("R7", "notify pulse", 64'(notify_pulse), 1);
      chk("R7", "notify index", 64'(notify_qidx), 2);
      @(posedge clk); #1; chk("R7", "notify one cycle", 64'(notify_pulse), 0);
      wr(12'h050, 9); chk("R7", "notify out of range", 64'(notify_pulse), 0);

      cur_tag = "R8";
      wr(12'h070, 1); wr(12'h070, 4);
      rd(12'h070, v); chk("R8", "status or", 64'(v), 5);

      cur_tag = "R10";
      @(posedge clk); #1 irq_set = 1'b1;
      @(posedge clk); #1 irq_set = 1'b0;
      chk("R10", "irq raised", 64'(irq), 1);
      @(posedge clk); #1 irq_set = 1'b1; addr = 12'h060; wr_data = 1; wr_en = 1'b1;
      @(posedge clk); #1 irq_set = 1'b0; wr_en = 1'b0;
      chk("R10", "set beats ack", 64'(irq), 1);
      wr(12'h060, 1); chk("R10", "ack clears", 64'(irq), 0);

      cur_tag = "R11";
      rd(12'h014, v); chk("R11", "write-only read", 64'(v), 0);
      rd(12'h0F0, v); chk("R11", "unmapped read", 64'(v), 0);
      wr(12'h000, 32'hDEAD_BEEF);
      rd(12'h000, v); chk("R11", "magic after write", 64'(v), 64'h7472_6976);

      cur_tag = "R13";
      wr(12'h028, 4096); chk("R13", "page size", 64'(page_size), 4096);
      rd(12'h028, v); chk("R11", "page size read", 64'(v), 0);

      cur_tag = "R12";
      wr(12'h103, 32'h1234_56A5);
      rd(12'h103, v); chk("R12", "cfg byte", 64'(v), 64'hA5);
      wr(12'h100 + CFGB, 32'h33);
      rd(12'h100 + CFGB, v); chk("R12", "cfg past end", 64'(v), 0);

      cur_tag = "R9";
      @(posedge clk); #1 irq_set = 1'b1;
      @(posedge clk); #1 irq_set = 1'b0;
      wr(12'h070, 0);
      chk("R9", "reset pulse", 64'(dev_reset_pulse), 1);
      chk("R9", "status cleared", 64'(dev_status), 0);
      chk("R9", "guest feats cleared", guest_feats, 0);
      chk("R9", "page cleared", 64'(page_size), 0);
      chk("R9", "irq cleared", 64'(irq), 0);
      chk("R9", "q0 pfn cleared", 64'(host_qpfn), 0);
      @(posedge clk); #1; chk("R9", "reset one cycle", 64'(dev_reset_pulse), 0);
      rd(12'h103, v); chk("R9", "cfg kept", 64'(v), 64'hA5);
      wr(12'h030, 2);
      rd(12'h040, v); chk("R9", "bank cleared", 64'(v), 0);

      repeat (2) @(posedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule